// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a host-side master for a 12-bit serial converter that runs in externally clocked mode. When it accepts a start request, it drops the active-low select while the serial clock sits low, so the converter uses the supplied clock. It then holds the clock still for a programmable wake-up interval. Next it issues sixteen idle-low clock pulses and captures one bit on every rising edge.

The captured 16-bit frame has three leading ones, then a channel bit, then twelve data bits, most significant first. When the sixteenth clock falls, the block raises select and pulses a done strobe for one cycle. At the same moment it presents the channel bit, the 12-bit result and a header error flag. After that, select stays high for a programmable gap before a new start can be taken.

All timing is counted in system clocks. The serial clock half period is a parameter. It is checked at elaboration against the allowed range of 100 kHz to 2.17 MHz. An out-of-range setting makes the block refuse every start.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, select is high, the serial clock is low and busy is low. After reset, done, header error, channel and result are 0.
- R2: A start is accepted only at a clock edge where busy is low. A start raised while busy has no effect on the frame in progress or on the frames that follow.
- R3: Select falls at the clock edge after an accepted start, with the serial clock low. The serial clock then stays low for WAKE_CYC system cycles.
- R4: After the wake interval, the serial clock runs with a period of 2*HALF_DIV system cycles, high for HALF_DIV and low for HALF_DIV. It gives exactly 16 rising edges per frame and is low whenever select is high.
- R5: Bits are taken from the data input on rising serial clock edges, and the first bit taken is frame bit 15. The result output is frame bits 11:0, and the channel output is frame bit 12.
- R6: Select rises together with the 16th falling serial clock edge. Done is high for exactly that one cycle. That is 1 + WAKE_CYC + 32*HALF_DIV cycles after the start was accepted.
- R7: Select then stays high, with busy still asserted, for DESEL_CYC cycles before the block is idle again. Back-to-back starts are spaced accordingly.
- R8: The header error output is 1 when frame bits 15:13 are not all ones, and 0 otherwise. The channel and result are presented in either case.
- R9: If SYS_HZ/(2*HALF_DIV) lies outside 100 kHz to 2.17 MHz, no start is ever accepted: select stays high and busy stays low.
- R10: Header error, channel and result change only in the cycle when done is high, and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| busy_o | output | 1 | Frame or select-high gap in progress |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idle low |
| sdata_i | input | 1 | Serial data from converter |
| done_o | output | 1 | One-cycle result strobe |
| chan_o | output | 1 | Channel bit of the last frame |
| result_o | output | DATA_W | Conversion result of the last frame |
| hdr_err_o | output | 1 | Last frame header was not three ones |

## Verification
The main instance is built at SYS_HZ = 20 MHz with HALF_DIV = 5, which gives a 2 MHz serial clock. It uses WAKE_CYC = 50 (2.5 µs) and DESEL_CYC = 3. With these values a whole frame and its gap take about 214 cycles, so back-to-back, overlapping-start and corrupted-header frames all fit into a short run. A second instance with HALF_DIV = 200 (50 kHz) shares the start line, and it shows the refusal path for an out-of-range divider. A behavioural converter model shifts the frames out on falling edges, and these frames include all-zero and all-one data on both channels.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int SYS_HZ    = 20_000_000,
  parameter int HALF_DIV  = 5,
  parameter int WAKE_CYC  = 50,
  parameter int DESEL_CYC = 3,
  parameter int DATA_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic              done_o,
  output logic              chan_o,
  output logic [DATA_W-1:0] result_o,
  output logic              hdr_err_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam longint F_MIN = 100_000;
  localparam longint F_MAX = 2_170_000;
  localparam longint TWO_H = 2 * longint'(HALF_DIV);
  localparam bit DIV_OK = (HALF_DIV >= 1) &&
                          (longint'(SYS_HZ) >= TWO_H * F_MIN) &&
                          (longint'(SYS_HZ) <= TWO_H * F_MAX);
  localparam int CMAX = (WAKE_CYC > DESEL_CYC) ?
                        ((WAKE_CYC > HALF_DIV) ? WAKE_CYC : HALF_DIV) :
                        ((DESEL_CYC > HALF_DIV) ? DESEL_CYC : HALF_DIV);
  localparam int CW = $clog2(CMAX + 1);
  localparam int BW = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_SHIFT, S_GAP} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     nbit;
  logic [FRAME_W-1:0] sr;

  assign busy_o = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      nbit      <= '0;
      sr        <= '0;
      cs_n_o    <= 1'b1;
      sclk_o    <= 1'b0;
      done_o    <= 1'b0;
      chan_o    <= 1'b0;
      result_o  <= '0;
      hdr_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i && DIV_OK) begin
            st     <= S_WAKE;
            cs_n_o <= 1'b0;
            cnt    <= '0;
          end
        end
        S_WAKE: begin
          if (cnt == CW'(WAKE_CYC - 1)) begin
            st   <= S_SHIFT;
            cnt  <= '0;
            nbit <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (cnt == CW'(HALF_DIV - 1)) begin
            cnt    <= '0;
            sclk_o <= ~sclk_o;
            if (!sclk_o) begin
              sr   <= {sr[FRAME_W-2:0], sdata_i};
              nbit <= nbit + 1'b1;
            end else if (nbit == BW'(FRAME_W)) begin
              st        <= S_GAP;
              cs_n_o    <= 1'b1;
              done_o    <= 1'b1;
              hdr_err_o <= (sr[FRAME_W-1 -: 3] != 3'b111);
              chan_o    <= sr[DATA_W];
              result_o  <= sr[DATA_W-1:0];
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(DESEL_CYC - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              done_o,
  input logic              chan_o,
  input logic [DATA_W-1:0] result_o,
  input logic              hdr_err_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && !sclk_o));

  assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

  assert_wake_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sclk_o);

  assert_clk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  assert_done_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && busy_o && $rose(cs_n_o)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_gap_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> cs_n_o);

  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(chan_o) && $stable(hdr_err_o)));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o), .chan_o(chan_o),
  .result_o(result_o), .hdr_err_o(hdr_err_o)
);

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int CLK_PERIOD = 50;
  localparam int H = 5;
  localparam int W = 50;
  localparam int D = 3;
  localparam int E_DONE = W + 32 * H + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, cs_n, sclk, sdata, done, chan, hdr;
  logic [11:0] res;
  logic busy_b, cs_n_b, sclk_b, done_b, chan_b, hdr_b;
  logic [11:0] res_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader #(.SYS_HZ(20_000_000), .HALF_DIV(H), .WAKE_CYC(W),
                     .DESEL_CYC(D), .DATA_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .cs_n_o(cs_n),
    .sclk_o(sclk), .sdata_i(sdata), .done_o(done), .chan_o(chan),
    .result_o(res), .hdr_err_o(hdr));

  adc_frame_reader #(.SYS_HZ(20_000_000), .HALF_DIV(200), .WAKE_CYC(W),
                     .DESEL_CYC(D), .DATA_W(12)) dut_bad (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_b), .cs_n_o(cs_n_b),
    .sclk_o(sclk_b), .sdata_i(1'b0), .done_o(done_b), .chan_o(chan_b),
    .result_o(res_b), .hdr_err_o(hdr_b));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural converter
  logic [15:0] sl_q[$];
  logic [15:0] sl_sr = 16'h0;
  always @(negedge cs_n) if (sl_q.size() > 0) sl_sr = sl_q.pop_front();
  always @(negedge sclk) if (!cs_n) sl_sr = {sl_sr[14:0], 1'b0};
  assign sdata = sl_sr[15];

  // reference model
  logic [15:0] exp_q[$];
  logic [15:0] cur = 16'h0;
  bit m_act = 0;
  int e = 0;
  int accepts = 0;
  logic [11:0] last_res = 12'h0;
  logic last_chan = 1'b0, last_hdr = 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!m_act && start) begin
        m_act = 1; e = 1; accepts++;
        cur = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0;
      end else if (m_act) begin
        e++;
        if (e == E_DONE + D) begin m_act = 0; e = 0; end
      end
    end
  end

  int cyc = 0;
  always @(negedge clk) begin
    bit x_cs, x_sclk, x_done;
    int s;
    cyc++;
    x_cs = !(m_act && e <= W + 32 * H);
    s = e - W - 1;
    x_sclk = m_act && e >= W + 1 && e <= W + 32 * H && (((s / H) % 2) == 1);
    x_done = m_act && e == E_DONE;
    chk(busy == m_act, "R2/R7 busy", busy, m_act);
    chk(cs_n == x_cs, "R3/R6/R7 cs_n", cs_n, x_cs);
    chk(sclk == x_sclk, "R3/R4 sclk", sclk, x_sclk);
    chk(done == x_done, "R6 done", done, x_done);
    if (x_done) begin
      last_res = cur[11:0];
      last_chan = cur[12];
      last_hdr = (cur[15:13] != 3'b111);
    end
    chk(res == last_res, "R5 result", res, last_res);
    chk(chan == last_chan, "R5 chan", chan, last_chan);
    chk(hdr == last_hdr, "R8 hdr_err", hdr, last_hdr);
    chk(!busy_b && cs_n_b && !sclk_b, "R9 bad divider idle",
        {cs_n_b, busy_b, sclk_b}, 3'b100);
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic one_frame(input logic [15:0] f);
    int a0;
    sl_q.push_back(f); exp_q.push_back(f);
    a0 = accepts;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(accepts == a0 + 1, "R2 accept", accepts, a0 + 1);
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && !sclk && !busy && !done && res == 0 && !chan && !hdr,
        "R1 reset", {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    one_frame(16'hEABC);              // R5 channel 0
    one_frame(16'hF123);              // R5 channel 1
    one_frame(16'hE000);              // R5 zero data
    one_frame(16'hFFFF);              // R5 full scale
    one_frame(16'h6555);              // R8 bad header
    one_frame(16'hB00F);              // R8 bad header, channel 1
    one_frame(16'hE7E7);              // R8 header good again
    // R2: start while busy is ignored
    sl_q.push_back(16'hF5A5); exp_q.push_back(16'hF5A5);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (m_act) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(accepts == 8, "R2 ignored start", accepts, 8);
    // R7: back-to-back starts
    sl_q.push_back(16'hE321); exp_q.push_back(16'hE321);
    sl_q.push_back(16'hFCDE); exp_q.push_back(16'hFCDE);
    @(negedge clk); start = 1'b1;
    while (accepts < 10) @(negedge clk);
    start = 1'b0;
    while (m_act) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(accepts == 10, "R7 back-to-back", accepts, 10);
    chk(res == 12'hCDE && chan == 1'b1 && !hdr, "R10 final hold",
        {hdr, chan, res}, {1'b0, 1'b1, 12'hCDE});
    finish_run();
  end
endmodule